// File: doc/BRIEF.md
# Prioritized CAN Transmit Buffer Scheduler

This block holds three outgoing message slots for a CAN controller and decides which of them goes onto the bus next. Each slot has a control byte and a data byte. The control byte carries a send request, a 2-bit priority and sticky outcome flags. When the protocol engine reports that the bus is free, the scheduler starts the best pending slot. It then waits for the engine to report the result: success, error or lost arbitration. It updates the slot and the interrupt flags from that result.

A host sees the block through a small register port. Writes happen on a clock edge and reads are combinational. The host can queue a slot, cancel a single slot, or hold a global cancel level that stops all sending. A slot that is already on the bus finishes before a cancel takes effect on it. A slot that has not started is dropped at once.

Top module: `can_tx_sched`

## Requirements
- R1: After synchronous reset every readable register (addresses 0..10) reads 0, `irq` is low and `tx_start` stays low.
- R2: `tx_start` pulses for one cycle only when `bus_idle` is high, no frame is in flight and at least one slot is requested. A request alone starts nothing. The slot stays in flight from that edge until `eng_done`.
- R3: Among the requested slots, the one with the largest priority field is started. Value 3 is the highest and value 0 the lowest. `tx_sel` names the slot.
- R4: When requested slots share the top priority, the one with the larger slot number is started.
- R5: A control write that raises the request bit clears that slot's error, lost and abort flags.
- R6: Slot n has its control byte at address 2n and its data byte at 2n+1. The control byte is laid out as bits 1:0 priority, bit 3 request, bit 4 error, bit 5 lost, bit 6 abort. While the request bit is set, writes to the priority and to the data byte are ignored.
- R7: An `eng_done` with `eng_res`=0 (success) clears the slot's request and sets its complete flag, bit n of address 10.
- R8: An `eng_done` with `eng_res`=1 (error) keeps the request, sets the slot's error flag and sets the message-error flag, bit 3 of address 10.
- R9: An `eng_done` with `eng_res`=2 (lost) keeps the request and sets the lost flag. The slot is started again at the next free bus.
- R10: While bit 0 of address 8 (cancel-all) is 1, pending slots that are not in flight lose their request and get the abort flag, and no start occurs. Sending resumes once the host writes it back to 0.
- R11: A host write of request=0 cancels a slot that is not in flight at once (abort flag set). For a slot in flight the cancel waits for `eng_done`. It then takes effect only if the frame failed or lost.
- R12: `irq` is the OR of the flags at address 10 ANDed with the enables at address 9. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Host write strobe |
| reg_addr | input | 4 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| bus_idle | input | 1 | Engine reports the bus free for a new frame |
| tx_start | output | 1 | Start-of-frame request to the engine |
| tx_sel | output | 2 | Slot being started or in flight |
| eng_done | input | 1 | Engine reports the end of the frame in flight |
| eng_res | input | 2 | Outcome: 0 success, 1 error, 2 lost arbitration |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume that the engine raises `eng_done` only while a frame is in flight. They also assume that `eng_res` holds one of the three defined codes whenever `eng_done` is high. The stimulus pulses `eng_done` for exactly one cycle, and only after a start it has observed. It always drives a defined code with it. A large sweep covers every priority assignment against every subset of requested slots. Each case first clears state with the cancel-all level, so every start happens with no frame left in flight.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
    localparam int NBUF   = 3;
    localparam int PW     = 2;
    localparam int DW     = 8;
    localparam int AW     = 4;
    localparam int IW     = $clog2(NBUF);
    localparam int FW     = NBUF + 1;
    localparam int REQ_BIT = 3;
    localparam logic [AW-1:0] A_GCTL = AW'(2 * NBUF + 2);
    localparam logic [AW-1:0] A_IEN  = AW'(2 * NBUF + 3);
    localparam logic [AW-1:0] A_IFLG = AW'(2 * NBUF + 4);

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_ERR  = 2'd1,
        RES_LOST = 2'd2
    } tx_res_e;

    typedef struct packed {
        logic          abrt;
        logic          lost;
        logic          err;
        logic          req;
        logic [PW-1:0] prio;
    } ctrl_t;

    typedef struct packed {
        logic          any;
        logic [IW-1:0] idx;
    } pick_t;

    function automatic logic [DW-1:0] ctrl_byte(ctrl_t c);
        return {1'b0, c.abrt, c.lost, c.err, c.req, 1'b0, c.prio};
    endfunction

    // Later index overwrites on equal priority: ties go to the larger slot.
    function automatic pick_t pick_winner(logic [NBUF-1:0] pend,
                                          logic [NBUF*PW-1:0] pv);
        pick_t         r;
        logic [PW-1:0] best;
        r    = '0;
        best = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (pend[i] && (!r.any || pv[i*PW +: PW] >= best)) begin
                r.any = 1'b1;
                r.idx = IW'(i);
                best  = pv[i*PW +: PW];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/can_tx_slot.sv
module can_tx_slot
    import can_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctrl,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    input  logic          abort_all,
    input  logic          engaged,
    input  logic          done_me,
    input  tx_res_e       res,
    output ctrl_t         st,
    output logic [DW-1:0] data_q
);
    logic abt_pend;
    logic cancel;

    assign cancel = abort_all | (wr_ctrl & st.req & ~wdata[REQ_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            abt_pend <= 1'b0;
        end else if (done_me) begin
            if (res == RES_OK) begin
                st.req <= 1'b0;
            end else begin
                if (res == RES_ERR)  st.err  <= 1'b1;
                if (res == RES_LOST) st.lost <= 1'b1;
                if (abt_pend || cancel) begin
                    st.req  <= 1'b0;
                    st.abrt <= 1'b1;
                end
            end
            abt_pend <= 1'b0;
        end else if (st.req && cancel) begin
            if (engaged) begin
                abt_pend <= 1'b1;
            end else begin
                st.req  <= 1'b0;
                st.abrt <= 1'b1;
            end
        end else if (wr_ctrl && !st.req) begin
            st.prio <= wdata[PW-1:0];
            if (wdata[REQ_BIT]) begin
                st.req  <= 1'b1;
                st.err  <= 1'b0;
                st.lost <= 1'b0;
                st.abrt <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            data_q <= '0;
        else if (wr_data && !st.req)
            data_q <= wdata;
    end
endmodule

// File: rtl/can_tx_pick.sv
module can_tx_pick
    import can_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NBUF-1:0]  req_vec,
    input  logic [NBUF*PW-1:0] prio_vec,
    input  logic             bus_idle,
    input  logic             abort_all,
    input  logic             eng_done,
    output logic             tx_start,
    output logic [IW-1:0]    tx_sel,
    output logic             busy,
    output logic [IW-1:0]    act
);
    pick_t win;

    always_comb begin
        win      = pick_winner(req_vec, prio_vec);
        tx_start = !busy && bus_idle && !abort_all && win.any;
        tx_sel   = busy ? act : win.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            act  <= '0;
        end else if (tx_start) begin
            busy <= 1'b1;
            act  <= win.idx;
        end else if (busy && eng_done) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/can_tx_irq.sv
module can_tx_irq
    import can_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_flg,
    input  logic [FW-1:0] wdata,
    input  logic [FW-1:0] set_vec,
    output logic [FW-1:0] ien,
    output logic [FW-1:0] iflg,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ien  <= '0;
            iflg <= '0;
        end else begin
            if (wr_en) ien <= wdata;
            for (int i = 0; i < FW; i++) begin
                if (set_vec[i])
                    iflg[i] <= 1'b1;
                else if (wr_flg && !wdata[i])
                    iflg[i] <= 1'b0;
            end
        end
    end

    assign irq = |(ien & iflg);
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
    import can_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          bus_idle,
    output logic          tx_start,
    output logic [IW-1:0] tx_sel,
    input  logic          eng_done,
    input  logic [1:0]    eng_res,
    output logic          irq
);
    ctrl_t              st   [NBUF];
    logic [DW-1:0]      dat  [NBUF];
    logic [NBUF-1:0]    req_vec;
    logic [NBUF*PW-1:0] prio_vec;
    logic [NBUF-1:0]    ok_vec;
    logic               err_any;
    logic               busy;
    logic [IW-1:0]      act;
    logic               abort_all;
    logic [FW-1:0]      ien, iflg;
    logic               merr_flag;
    tx_res_e            res;

    assign res       = tx_res_e'(eng_res);
    assign merr_flag = iflg[NBUF];

    always_ff @(posedge clk) begin
        if (rst)
            abort_all <= 1'b0;
        else if (reg_we && reg_addr == A_GCTL)
            abort_all <= reg_wdata[0];
    end

    logic [NBUF-1:0] err_vec;

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        logic on_bus, done_me;
        assign on_bus  = busy && act == IW'(g);
        assign done_me = on_bus && eng_done;

        can_tx_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_ctrl   (reg_we && reg_addr == AW'(2 * g)),
            .wr_data   (reg_we && reg_addr == AW'(2 * g + 1)),
            .wdata     (reg_wdata),
            .abort_all (abort_all),
            .engaged   (on_bus || (tx_start && tx_sel == IW'(g))),
            .done_me   (done_me),
            .res       (res),
            .st        (st[g]),
            .data_q    (dat[g])
        );

        assign req_vec[g]          = st[g].req;
        assign prio_vec[g*PW +: PW] = st[g].prio;
        assign ok_vec[g]           = done_me && res == RES_OK;
        assign err_vec[g]          = done_me && res == RES_ERR;
    end

    assign err_any = |err_vec;

    can_tx_pick u_pick (
        .clk       (clk),
        .rst       (rst),
        .req_vec   (req_vec),
        .prio_vec  (prio_vec),
        .bus_idle  (bus_idle),
        .abort_all (abort_all),
        .eng_done  (eng_done),
        .tx_start  (tx_start),
        .tx_sel    (tx_sel),
        .busy      (busy),
        .act       (act)
    );

    can_tx_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we && reg_addr == A_IEN),
        .wr_flg  (reg_we && reg_addr == A_IFLG),
        .wdata   (reg_wdata[FW-1:0]),
        .set_vec ({err_any, ok_vec}),
        .ien     (ien),
        .iflg    (iflg),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (reg_addr == AW'(2 * i))     reg_rdata = ctrl_byte(st[i]);
            if (reg_addr == AW'(2 * i + 1)) reg_rdata = dat[i];
        end
        if (reg_addr == A_GCTL) reg_rdata = {{(DW-1){1'b0}}, abort_all};
        if (reg_addr == A_IEN)  reg_rdata = DW'(ien);
        if (reg_addr == A_IFLG) reg_rdata = DW'(iflg);
    end
endmodule

// File: rtl/can_tx_sched_chk.sv
module can_tx_sched_chk
    import can_tx_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               tx_start,
    input logic [IW-1:0]      tx_sel,
    input logic               bus_idle,
    input logic               abort_all,
    input logic               busy,
    input logic [IW-1:0]      act,
    input logic [NBUF-1:0]    req_vec,
    input logic [NBUF*PW-1:0] prio_vec,
    input logic               eng_done,
    input logic [1:0]         eng_res,
    input logic               merr_flag
);
    function automatic logic [PW-1:0] prio_of(logic [NBUF*PW-1:0] pv, logic [IW-1:0] k);
        logic [PW-1:0] r;
        r = '0;
        for (int i = 0; i < NBUF; i++) if (k == IW'(i)) r = pv[i*PW +: PW];
        return r;
    endfunction

    function automatic logic req_of(logic [NBUF-1:0] rv, logic [IW-1:0] k);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NBUF; i++) if (k == IW'(i)) r = rv[i];
        return r;
    endfunction

    function automatic logic none_better(logic [NBUF-1:0] rv, logic [NBUF*PW-1:0] pv,
                                         logic [IW-1:0] s);
        logic ok;
        ok = 1'b1;
        for (int j = 0; j < NBUF; j++) begin
            if (rv[j] && (pv[j*PW +: PW] > prio_of(pv, s) ||
                          (pv[j*PW +: PW] == prio_of(pv, s) && IW'(j) > s)))
                ok = 1'b0;
        end
        return ok;
    endfunction

    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> bus_idle && !busy && req_of(req_vec, tx_sel));

    // R3 and R4: no requested slot beats the chosen one
    p_pick_best_r3: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> none_better(req_vec, prio_vec, tx_sel));

    p_ok_clears_r7: assert property (@(posedge clk) disable iff (rst)
        busy && eng_done && eng_res == 2'd0 |=> !req_of(req_vec, $past(act)));

    p_err_flag_r8: assert property (@(posedge clk) disable iff (rst)
        busy && eng_done && eng_res == 2'd1 |=> merr_flag);

    p_no_start_abort_r10: assert property (@(posedge clk) disable iff (rst)
        abort_all |-> !tx_start);

    p_inflight_kept_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> req_of(req_vec, act));
endmodule

bind can_tx_sched can_tx_sched_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_start  (tx_start),
    .tx_sel    (tx_sel),
    .bus_idle  (bus_idle),
    .abort_all (abort_all),
    .busy      (busy),
    .act       (act),
    .req_vec   (req_vec),
    .prio_vec  (prio_vec),
    .eng_done  (eng_done),
    .eng_res   (eng_res),
    .merr_flag (merr_flag)
);

// File: tb/can_tx_sched_tb.sv
module can_tx_sched_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bus_idle = 1'b0;
    logic       tx_start;
    logic [1:0] tx_sel;
    logic       eng_done = 1'b0;
    logic [1:0] eng_res = '0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    can_tx_sched dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_idle(bus_idle),
        .tx_start(tx_start), .tx_sel(tx_sel), .eng_done(eng_done),
        .eng_res(eng_res), .irq(irq)
    );

    task automatic check(string rq, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", rq, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rdchk(string rq, logic [3:0] a, logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(rq, d, exp);
    endtask

    // Raise bus_idle for one cycle and sample the start outputs
    task automatic try_start(string rq, logic exp_start, logic [1:0] exp_sel);
        @(negedge clk);
        bus_idle = 1'b1;
        #1;
        check(rq, {7'd0, tx_start}, {7'd0, exp_start});
        if (exp_start) check(rq, {6'd0, tx_sel}, {6'd0, exp_sel});
        @(negedge clk);
        bus_idle = 1'b0;
    endtask

    task automatic finish_frame(logic [1:0] r);
        @(negedge clk);
        eng_done = 1'b1; eng_res = r;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    initial begin
        while (!done_flag) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a <= 10; a++) rdchk("R1", 4'(a), 8'h00);
        check("R1", {7'd0, irq}, 8'h00);
        check("R1", {7'd0, tx_start}, 8'h00);

        // R6, R2: write protection while requested; no start without bus_idle
        wr(9, 8'h08);
        wr(0, 8'h0A);
        wr(0, 8'h0B);
        rdchk("R6", 0, 8'h0A);
        wr(1, 8'h55);
        rdchk("R6", 1, 8'h00);
        @(negedge clk); #1;
        check("R2", {7'd0, tx_start}, 8'h00);

        // R8: error keeps request, sets flags and irq
        try_start("R2", 1'b1, 2'd0);
        finish_frame(2'd1);
        rdchk("R8", 0, 8'h1A);
        rdchk("R8", 10, 8'h08);
        check("R12", {7'd0, irq}, 8'h01);

        // R9: lost arbitration, then retry succeeds
        try_start("R9", 1'b1, 2'd0);
        finish_frame(2'd2);
        rdchk("R9", 0, 8'h3A);
        try_start("R9", 1'b1, 2'd0);
        finish_frame(2'd0);
        rdchk("R7", 0, 8'h32);
        rdchk("R7", 10, 8'h09);

        // R12: clear-by-zero, enables
        wr(10, 8'h01);
        rdchk("R12", 10, 8'h01);
        check("R12", {7'd0, irq}, 8'h00);
        wr(9, 8'h01);
        check("R12", {7'd0, irq}, 8'h01);
        wr(10, 8'h00);
        check("R12", {7'd0, irq}, 8'h00);

        // R5: re-request clears sticky flags
        wr(0, 8'h08);
        rdchk("R5", 0, 8'h08);

        // R11: immediate cancel of a waiting slot
        wr(0, 8'h00);
        rdchk("R11", 0, 8'h40);

        // R11: deferred cancel of the slot in flight
        wr(2, 8'h09);
        try_start("R11", 1'b1, 2'd1);
        wr(2, 8'h00);
        rdchk("R11", 2, 8'h09);
        finish_frame(2'd2);
        rdchk("R11", 2, 8'h61);
        try_start("R11", 1'b0, 2'd0);

        // R10: cancel-all level
        wr(4, 8'h0B);
        wr(8, 8'h01);
        rdchk("R10", 4, 8'h43);
        wr(4, 8'h0B);
        try_start("R10", 1'b0, 2'd0);
        rdchk("R10", 4, 8'h43);
        wr(8, 8'h00);
        wr(4, 8'h0B);
        rdchk("R5", 4, 8'h0B);
        try_start("R10", 1'b1, 2'd2);
        finish_frame(2'd0);

        // R3, R4, R7: every priority set against every request subset
        for (int p = 0; p < 64; p++) begin
            for (int m = 0; m < 8; m++) begin
                int best_score;
                int best_idx;
                best_score = -1;
                best_idx   = 0;
                wr(8, 8'h01);
                wr(8, 8'h00);
                for (int i = 0; i < 3; i++) begin
                    int pr;
                    pr = (p >> (2 * i)) & 3;
                    wr(4'(2 * i), 8'(pr | (((m >> i) & 1) << 3)));
                    if (((m >> i) & 1) == 1 && pr * 4 + i > best_score) begin
                        best_score = pr * 4 + i;
                        best_idx   = i;
                    end
                end
                try_start("R3/R4", best_score >= 0, 2'(best_idx));
                if (best_score >= 0) begin
                    logic [7:0] d;
                    finish_frame(2'd0);
                    rd(4'(2 * best_idx), d);
                    check("R7", {7'd0, d[3]}, 8'h00);
                end
            end
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule